// File: doc/BRIEF.md
# Module slot controller with recovery gap and interrupt status

This block manages four plug-in module slots behind a small 16-bit register window. A host port asks for a bus cycle to one slot in one of four address spaces (identification, interrupt, I/O, memory). The block grants the start only when that slot's recovery gap has run out. It drives the per-slot interrupt-select strobe for interrupt-space cycles. It ends the cycle either on the slot's acknowledge or on a timeout measured in module clock ticks. The data transfer itself, the generation of the module clocks and any bridge logic live outside.

Software sees a fixed revision word, one control word per slot and a reset word. Writing bit 0 of the reset word starts a self-ending module reset pulse. Software also sees a 16-bit status word. It holds the interrupt request bits, which are latched on falling edges or follow the live line depending on the slot's mode. It also holds sticky timeout flags cleared by writing one, and live mirrors of the slots' error inputs. The `host_irq` output is the OR of every interrupt bit and every timeout flag that its slot enables.

The cycle engine is an FSM with states IDLE, ACTIVE and DONE:
- IDLE to ACTIVE when a request is pending and the addressed slot is ready.
- ACTIVE to DONE on the slot's acknowledge, or on the last allowed tick.
- DONE to IDLE unconditionally.

The reset generator is an FSM with states IDLE and PULSE:
- IDLE to PULSE on a start write.
- PULSE to PULSE on a further start write, which reloads the count.
- PULSE to IDLE when the count is used up.

Top module: `slotctl_top`

## Requirements
- R1: While `rst_n` is low, `mod_rst_n` is low and every `mod_intsel_n` bit is high. After reset the control words, the status word (with all error and request lines released) and `host_irq` are zero, and `cyc_busy` is low.
- R2: Word offsets (byte address, bit 0 ignored):
  - 0x00 reads `REV_ID` and ignores writes.
  - 0x02, 0x04, 0x06 and 0x08 are the control words of slots 0 to 3. Bits 4:0 are stored and read back, and the upper bits read zero.
  - 0x0A is the reset word and reads zero.
  - 0x0C is the status word.
  - 0x0E and above read zero.
- R3: Writing the reset word with bit 0 set drives `mod_rst_n` low for exactly `RST_CYC` clock cycles, starting with the cycle after the write. A write with bit 0 clear has no effect.
- R4: A reset-start write during a running pulse restarts the count, so the low time is the elapsed time plus `RST_CYC`.
- R5: A held `cyc_req` to a ready slot starts the cycle at the next edge, so `cyc_busy` rises. `cyc_busy` stays high until the edge that samples `mod_ack` of that slot. `cyc_done` is then high for exactly one cycle, and `cyc_req` must be released while `cyc_done` is high.
- R6: With control bit 0 (recovery enable) set, a new cycle to a slot starts no earlier than `RECOV_CYC` cycles after its previous cycle ended. Other slots are not delayed. With the bit clear, a re-request raised in the cycle after `cyc_done` gets `cyc_busy` one cycle later.
- R7: If no acknowledge arrives within `TMO_TICKS` selected ticks, the cycle ends. `cyc_timeout` is high alongside `cyc_done`, and status bit 8+slot is set. It stays set until a write of 1 to that bit; writing 0 has no effect.
- R8: Control bit 1 selects the fast tick (`tick_fast`) for the slot's timeout; clear selects `tick_slow`. The bit is also driven on `mod_fast[slot]`.
- R9: During a cycle in the interrupt space (`cyc_space` = 2'b01), only `mod_intsel_n` of the addressed slot is low. It is high in all other cycles and spaces.
- R10: Status bits 15:12 read 1 while `mod_err_n[slot]` is low. Writes to them have no effect.
- R11: Request line i (slot i/2, request i%2) maps to status bit i. In edge mode (control bit 3 for request 0, bit 4 for request 1), a falling edge of `mod_irq_n[i]` latches the bit. Writing 1 clears it; writing 0 has no effect.
- R12: In level mode the status bit equals the inverted live `mod_irq_n[i]`, and writes do not change it.
- R13: `host_irq` is high when any status bit 7:0 is set, or when a timeout flag is set whose slot has control bit 2 (timeout interrupt enable) set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Board reset, active low |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational |
| cyc_req | input | 1 | Cycle request, held until `cyc_done` |
| cyc_slot | input | 2 | Requested slot |
| cyc_space | input | 2 | Space: 00 ID, 01 interrupt, 10 I/O, 11 memory |
| cyc_busy | output | 1 | Cycle running |
| cyc_done | output | 1 | One-cycle end marker |
| cyc_timeout | output | 1 | Cycle ended by timeout (valid with `cyc_done`) |
| tick_slow | input | 1 | Slow module clock tick |
| tick_fast | input | 1 | Fast module clock tick |
| mod_ack | input | 4 | Per-slot acknowledge |
| mod_err_n | input | 4 | Per-slot error line, active low |
| mod_irq_n | input | 8 | Two request lines per slot, active low |
| mod_rst_n | output | 1 | Module reset, active low |
| mod_intsel_n | output | 4 | Interrupt-select strobes, active low |
| mod_fast | output | 4 | Per-slot fast clock select |
| host_irq | output | 1 | Combined interrupt |

## Verification
The bench sets `RECOV_CYC` to 6, `TMO_TICKS` to 4 and `RST_CYC` to 10. At these values the exact recovery gap, the timeout length and the reset pulse length can be counted cycle by cycle and compared with the parameters. The bench sweeps every slot against every space, every error pattern and all 256 level request patterns. It steps every request line through edge latching and clearing. It also runs the timeout against both tick sources.

// File: rtl/slotctl_pkg.sv
package slotctl_pkg;

    typedef enum logic [1:0] {
        SP_ID  = 2'b00,
        SP_INT = 2'b01,
        SP_IO  = 2'b10,
        SP_MEM = 2'b11
    } space_e;

    typedef enum logic [1:0] {
        CY_IDLE   = 2'd0,
        CY_ACTIVE = 2'd1,
        CY_DONE   = 2'd2
    } cyc_state_e;

    typedef enum logic {
        RG_IDLE  = 1'b0,
        RG_PULSE = 1'b1
    } rst_state_e;

    // control word bit positions
    localparam int unsigned CTL_RECOV = 0;
    localparam int unsigned CTL_FAST  = 1;
    localparam int unsigned CTL_TMOEN = 2;
    localparam int unsigned CTL_EDGE0 = 3;
    localparam int unsigned CTL_W     = 5;

    // word indices (byte address >> 1)
    localparam logic [6:0] W_REV  = 7'd0;
    localparam logic [6:0] W_RST  = 7'd5;
    localparam logic [6:0] W_STAT = 7'd6;

endpackage

// File: rtl/slotctl_recover.sv
module slotctl_recover #(
    parameter int unsigned RECOV_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic load,
    output logic ready
);
    localparam int unsigned CW = $clog2(RECOV_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load && en) begin
            cnt_q <= CW'(RECOV_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb ready = (cnt_q == '0);

    // R6: a slot whose cycle just ended with recovery enabled is not ready next cycle
    a_r6_gap_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (load && en) |=> !ready);

endmodule

// File: rtl/slotctl_resetgen.sv
module slotctl_resetgen import slotctl_pkg::*; #(
    parameter int unsigned RST_CYC = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic rst_out_n
);
    localparam int unsigned CW = $clog2(RST_CYC + 1);

    rst_state_e    state_q, state_n;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RG_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            RG_IDLE:  if (fire) state_n = RG_PULSE;
            RG_PULSE: if (!fire && cnt_q == CW'(1)) state_n = RG_IDLE;
            default:  state_n = RG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (fire) begin
            cnt_q <= CW'(RST_CYC);
        end else if (state_q == RG_PULSE && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb rst_out_n = rst_n && (state_q == RG_IDLE);

    // R3: a start write drives the module reset low from the next cycle
    a_r3_fire_low: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !rst_out_n);

    // R4: the pulse ends once the last count is spent without a new start
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RG_PULSE && !fire && cnt_q == CW'(1)) |=> rst_out_n);

endmodule

// File: rtl/slotctl_cycle.sv
module slotctl_cycle import slotctl_pkg::*; #(
    parameter int unsigned N_SLOTS   = 4,
    parameter int unsigned TMO_TICKS = 32,
    localparam int unsigned SW = $clog2(N_SLOTS),
    localparam int unsigned TW = $clog2(TMO_TICKS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [SW-1:0]      slot,
    input  logic [1:0]         space,
    input  logic [N_SLOTS-1:0] ready,
    input  logic [N_SLOTS-1:0] fast,
    input  logic               tick_slow,
    input  logic               tick_fast,
    input  logic [N_SLOTS-1:0] ack,
    output logic               busy,
    output logic               done,
    output logic               timeout,
    output logic [N_SLOTS-1:0] intsel_n,
    output logic               end_pulse,
    output logic [SW-1:0]      end_slot,
    output logic [N_SLOTS-1:0] tmo_set
);
    cyc_state_e    state_q, state_n;
    logic [SW-1:0] slot_q;
    logic [1:0]    space_q;
    logic [TW-1:0] tick_cnt_q;
    logic          tmo_q;
    logic          tick_sel, tmo_hit, ack_hit, start;

    always_comb begin
        tick_sel = fast[slot_q] ? tick_fast : tick_slow;
        tmo_hit  = tick_sel && (tick_cnt_q == TW'(TMO_TICKS - 1));
        ack_hit  = ack[slot_q];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CY_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            CY_IDLE:   if (req && ready[slot]) state_n = CY_ACTIVE;
            CY_ACTIVE: if (ack_hit || tmo_hit) state_n = CY_DONE;
            CY_DONE:   state_n = CY_IDLE;
            default:   state_n = CY_IDLE;
        endcase
    end

    always_comb start = (state_q == CY_IDLE) && (state_n == CY_ACTIVE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q     <= '0;
            space_q    <= SP_ID;
            tick_cnt_q <= '0;
            tmo_q      <= 1'b0;
        end else if (start) begin
            slot_q     <= slot;
            space_q    <= space;
            tick_cnt_q <= '0;
            tmo_q      <= 1'b0;
        end else if (state_q == CY_ACTIVE) begin
            if (tick_sel) tick_cnt_q <= tick_cnt_q + 1'b1;
            if (tmo_hit && !ack_hit) tmo_q <= 1'b1;
        end
    end

    always_comb begin
        busy      = (state_q == CY_ACTIVE);
        done      = (state_q == CY_DONE);
        timeout   = (state_q == CY_DONE) && tmo_q;
        end_pulse = (state_q == CY_ACTIVE) && (ack_hit || tmo_hit);
        end_slot  = slot_q;
        for (int s = 0; s < N_SLOTS; s++) begin
            intsel_n[s] = !((state_q == CY_ACTIVE) && (space_q == SP_INT) && (slot_q == SW'(s)));
            tmo_set[s]  = (state_q == CY_ACTIVE) && tmo_hit && !ack_hit && (slot_q == SW'(s));
        end
    end

    // R9: at most one interrupt-select strobe, and only inside a cycle
    a_r9_intsel_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~intsel_n));
    a_r9_intsel_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (intsel_n != '1) |-> busy);
    // R7: the tick counter never passes the timeout limit inside a cycle
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CY_ACTIVE) |-> (tick_cnt_q < TW'(TMO_TICKS)));
    // R5: the end marker lasts one cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6: a cycle only starts on a ready slot
    a_r6_start_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CY_IDLE && req && !ready[slot]) |=> !busy);

endmodule

// File: rtl/slotctl_regs.sv
module slotctl_regs import slotctl_pkg::*; #(
    parameter int unsigned N_SLOTS = 4,
    parameter logic [15:0] REV_ID  = 16'h0012,
    localparam int unsigned NL     = 2 * N_SLOTS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         addr,
    input  logic               we,
    input  logic [15:0]        wdata,
    output logic [15:0]        rdata,
    input  logic [N_SLOTS-1:0] err_n,
    input  logic [NL-1:0]      irq_n,
    input  logic [N_SLOTS-1:0] tmo_set,
    output logic [N_SLOTS-1:0] recov_en,
    output logic [N_SLOTS-1:0] fast,
    output logic               rst_fire,
    output logic               host_irq
);
    logic [6:0]                      word;
    logic                            wr_stat;
    logic [N_SLOTS-1:0][CTL_W-1:0]   ctrl_q;
    logic [N_SLOTS-1:0]              tmo_q;
    logic [N_SLOTS-1:0]              tmo_en;
    logic [NL-1:0]                   irq_prev_q, edge_q, int_bit, edge_mode;
    logic [15:0]                     status;

    always_comb begin
        word     = addr[7:1];
        wr_stat  = we && (word == W_STAT);
        rst_fire = we && (word == W_RST) && wdata[0];
    end

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        ctrl_q[s] <= '0;
            else if (we && word == 7'(s + 1))  ctrl_q[s] <= wdata[CTL_W-1:0];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                tmo_q[s] <= 1'b0;
            else if (tmo_set[s])                       tmo_q[s] <= 1'b1;
            else if (wr_stat && wdata[NL + s])         tmo_q[s] <= 1'b0;
        end

        always_comb begin
            recov_en[s] = ctrl_q[s][CTL_RECOV];
            fast[s]     = ctrl_q[s][CTL_FAST];
            tmo_en[s]   = ctrl_q[s][CTL_TMOEN];
        end
    end

    for (genvar i = 0; i < NL; i++) begin : g_line
        always_comb edge_mode[i] = ctrl_q[i / 2][CTL_EDGE0 + (i % 2)];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                irq_prev_q[i] <= 1'b1;
                edge_q[i]     <= 1'b0;
            end else begin
                irq_prev_q[i] <= irq_n[i];
                if (!edge_mode[i])                    edge_q[i] <= 1'b0;
                else if (irq_prev_q[i] && !irq_n[i])  edge_q[i] <= 1'b1;
                else if (wr_stat && wdata[i])         edge_q[i] <= 1'b0;
            end
        end

        always_comb int_bit[i] = edge_mode[i] ? edge_q[i] : !irq_n[i];

        // R11: a falling request edge in edge mode is latched
        a_r11_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(irq_n[i]) && edge_mode[i] && !we) |=> int_bit[i]);
    end

    always_comb begin
        status   = {~err_n, tmo_q, int_bit};
        host_irq = (|int_bit) || (|(tmo_q & tmo_en));
        rdata    = '0;
        if (word == W_REV) begin
            rdata = REV_ID;
        end else if (word == W_STAT) begin
            rdata = status;
        end else begin
            for (int s = 0; s < N_SLOTS; s++) begin
                if (word == 7'(s + 1)) rdata[CTL_W-1:0] = ctrl_q[s];
            end
        end
    end

    // R7: a write of one clears the timeout flag when no new timeout arrives
    a_r7_tmo_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && tmo_set == '0) |=> ((tmo_q & $past(wdata[NL+N_SLOTS-1:NL])) == '0));
    // R7: a new timeout always shows up in the status word
    a_r7_tmo_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_set != '0) |=> ((tmo_q & $past(tmo_set)) == $past(tmo_set)));

endmodule

// File: rtl/slotctl_top.sv
module slotctl_top import slotctl_pkg::*; #(
    parameter int unsigned N_SLOTS   = 4,
    parameter int unsigned RECOV_CYC = 125,
    parameter int unsigned TMO_TICKS = 32,
    parameter int unsigned RST_CYC   = 25000,
    parameter logic [15:0] REV_ID    = 16'h0012
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  reg_addr,
    input  logic        reg_we,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        cyc_req,
    input  logic [1:0]  cyc_slot,
    input  logic [1:0]  cyc_space,
    output logic        cyc_busy,
    output logic        cyc_done,
    output logic        cyc_timeout,
    input  logic        tick_slow,
    input  logic        tick_fast,
    input  logic [3:0]  mod_ack,
    input  logic [3:0]  mod_err_n,
    input  logic [7:0]  mod_irq_n,
    output logic        mod_rst_n,
    output logic [3:0]  mod_intsel_n,
    output logic [3:0]  mod_fast,
    output logic        host_irq
);
    localparam int unsigned SW = $clog2(N_SLOTS);

    logic [N_SLOTS-1:0] recov_en, fast, ready, tmo_set;
    logic               end_pulse, rst_fire;
    logic [SW-1:0]      end_slot;

    slotctl_regs #(.N_SLOTS(N_SLOTS), .REV_ID(REV_ID)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (reg_addr),
        .we       (reg_we),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .err_n    (mod_err_n),
        .irq_n    (mod_irq_n),
        .tmo_set  (tmo_set),
        .recov_en (recov_en),
        .fast     (fast),
        .rst_fire (rst_fire),
        .host_irq (host_irq)
    );

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_recov
        slotctl_recover #(.RECOV_CYC(RECOV_CYC)) u_recov (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (recov_en[s]),
            .load  (end_pulse && end_slot == SW'(s)),
            .ready (ready[s])
        );
    end

    slotctl_cycle #(.N_SLOTS(N_SLOTS), .TMO_TICKS(TMO_TICKS)) u_cycle (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (cyc_req),
        .slot      (cyc_slot),
        .space     (cyc_space),
        .ready     (ready),
        .fast      (fast),
        .tick_slow (tick_slow),
        .tick_fast (tick_fast),
        .ack       (mod_ack),
        .busy      (cyc_busy),
        .done      (cyc_done),
        .timeout   (cyc_timeout),
        .intsel_n  (mod_intsel_n),
        .end_pulse (end_pulse),
        .end_slot  (end_slot),
        .tmo_set   (tmo_set)
    );

    slotctl_resetgen #(.RST_CYC(RST_CYC)) u_rstgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (rst_fire),
        .rst_out_n (mod_rst_n)
    );

    always_comb mod_fast = fast;

endmodule

// File: tb/slotctl_top_tb.sv
module slotctl_top_tb;
    localparam int unsigned RC  = 6;
    localparam int unsigned TT  = 4;
    localparam int unsigned RTC = 10;
    localparam logic [15:0] REV = 16'h0A5C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cyc_req = 1'b0;
    logic [1:0]  cyc_slot = '0;
    logic [1:0]  cyc_space = '0;
    logic        cyc_busy, cyc_done, cyc_timeout;
    logic        tick_slow = 1'b0;
    logic        tick_fast = 1'b1;
    logic [3:0]  mod_ack = '0;
    logic [3:0]  mod_err_n = '1;
    logic [7:0]  mod_irq_n = '1;
    logic        mod_rst_n;
    logic [3:0]  mod_intsel_n, mod_fast;
    logic        host_irq;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    slotctl_top #(.RECOV_CYC(RC), .TMO_TICKS(TT), .RST_CYC(RTC), .REV_ID(REV)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_req(cyc_req),
        .cyc_slot(cyc_slot), .cyc_space(cyc_space), .cyc_busy(cyc_busy),
        .cyc_done(cyc_done), .cyc_timeout(cyc_timeout), .tick_slow(tick_slow),
        .tick_fast(tick_fast), .mod_ack(mod_ack), .mod_err_n(mod_err_n),
        .mod_irq_n(mod_irq_n), .mod_rst_n(mod_rst_n), .mod_intsel_n(mod_intsel_n),
        .mod_fast(mod_fast), .host_irq(host_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic do_cycle(input int s, input logic [1:0] sp, input int ack_at,
                            output int wait_n, output int busy_n,
                            output logic [3:0] isel, output logic tmo, output logic dn);
        cyc_slot = 2'(s); cyc_space = sp; cyc_req = 1'b1;
        wait_n = 0; busy_n = 0;
        do begin @(negedge clk); wait_n++; end while (!cyc_busy && wait_n < 1000);
        isel = ~mod_intsel_n;
        while (cyc_busy && busy_n < 1000) begin
            busy_n++;
            if (ack_at > 0 && busy_n == ack_at) mod_ack[s] = 1'b1;
            @(negedge clk);
        end
        tmo = cyc_timeout; dn = cyc_done;
        mod_ack = '0; cyc_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int w, b, cnt;
        logic [3:0] is;
        logic t, dn;

        repeat (3) @(negedge clk);
        chk("R1 mod_rst_n in reset", 32'(mod_rst_n), 0);
        chk("R1 intsel in reset", 32'(mod_intsel_n), 32'hF);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mod_rst_n after reset", 32'(mod_rst_n), 1);
        chk("R1 busy after reset", 32'(cyc_busy), 0);
        chk("R1 host_irq after reset", 32'(host_irq), 0);
        rd(8'h0C, d); chk("R1 status after reset", 32'(d), 0);
        for (int s = 0; s < 4; s++) begin
            rd(8'(2 + 2*s), d); chk("R1 control after reset", 32'(d), 0);
        end

        // R2 register map
        rd(8'h00, d); chk("R2 revision", 32'(d), 32'(REV));
        wr(8'h00, 16'h1234);
        rd(8'h00, d); chk("R2 revision ignores write", 32'(d), 32'(REV));
        rd(8'h0A, d); chk("R2 reset word reads zero", 32'(d), 0);
        for (int a = 8'h0E; a < 256; a += 18) begin
            rd(8'(a), d); chk("R2 unused offset", 32'(d), 0);
        end
        for (int s = 0; s < 4; s++) wr(8'(2 + 2*s), 16'hFFE0 | 16'((s*7 + 19) & 31));
        for (int s = 0; s < 4; s++) begin
            rd(8'(2 + 2*s), d); chk("R2 control readback", 32'(d), 32'((s*7 + 19) & 31));
            rd(8'(3 + 2*s), d); chk("R2 control odd address", 32'(d), 32'((s*7 + 19) & 31));
        end
        for (int s = 0; s < 4; s++) wr(8'(2 + 2*s), 16'h0000);
        // clear any edge latches or flags possibly collected
        wr(8'h0C, 16'hFFFF);

        // R3 reset pulse
        wr(8'h0A, 16'hFFFE);
        cnt = 0;
        repeat (RTC + 3) begin cnt += 32'(!mod_rst_n); @(negedge clk); end
        chk("R3 write without bit 0", 32'(cnt), 0);
        wr(8'h0A, 16'h0001);
        cnt = 0;
        while (!mod_rst_n && cnt < 1000) begin cnt++; @(negedge clk); end
        chk("R3 pulse length", 32'(cnt), 32'(RTC));
        // R4 restart
        wr(8'h0A, 16'h0001);
        cnt = 0;
        repeat (3) begin cnt += 32'(!mod_rst_n); @(negedge clk); end
        cnt += 32'(!mod_rst_n);
        wr(8'h0A, 16'h0001);
        while (!mod_rst_n && cnt < 1000) begin cnt++; @(negedge clk); end
        chk("R4 restarted pulse length", 32'(cnt), 32'(4 + RTC));

        // R5 / R9 sweep of slots and spaces
        for (int s = 0; s < 4; s++) begin
            for (int sp = 0; sp < 4; sp++) begin
                do_cycle(s, 2'(sp), 1, w, b, is, t, dn);
                chk("R5 busy length with ack", 32'(b), 1);
                chk("R5 done marker", 32'(dn), 1);
                chk("R5 no timeout on ack", 32'(t), 0);
                chk("R9 intsel pattern", 32'(is), (sp == 1) ? 32'(1 << s) : 0);
                chk("R9 intsel idle", 32'(mod_intsel_n), 32'hF);
            end
        end

        // R6 recovery gap
        for (int s = 0; s < 4; s++) begin
            wr(8'(2 + 2*s), 16'h0001);
            do_cycle(s, 2'b10, 1, w, b, is, t, dn);
            chk("R6 first cycle not delayed", 32'(w), 1);
            do_cycle(s, 2'b10, 1, w, b, is, t, dn);
            chk("R6 gap on same slot", 32'(w), 32'(RC));
            do_cycle((s + 1) % 4, 2'b10, 1, w, b, is, t, dn);
            chk("R6 other slot not delayed", 32'(w), 1);
            wr(8'(2 + 2*s), 16'h0000);
        end
        do_cycle(2, 2'b11, 1, w, b, is, t, dn);
        do_cycle(2, 2'b11, 1, w, b, is, t, dn);
        chk("R6 disabled gap", 32'(w), 1);

        // R7 / R8 / R13 timeout
        for (int s = 0; s < 4; s++) begin
            wr(8'(2 + 2*s), 16'h0006);
            chk("R8 fast select output", 32'(mod_fast), 32'(1 << s));
            tick_fast = 1'b1; tick_slow = 1'b0;
            do_cycle(s, 2'b00, 0, w, b, is, t, dn);
            chk("R7 timeout length", 32'(b), 32'(TT));
            chk("R7 timeout marker", 32'(t), 1);
            rd(8'h0C, d); chk("R7 timeout flag", 32'(d), 32'(1 << (8 + s)));
            chk("R13 irq from enabled timeout", 32'(host_irq), 1);
            wr(8'h0C, 16'h0000);
            rd(8'h0C, d); chk("R7 write zero keeps flag", 32'(d), 32'(1 << (8 + s)));
            wr(8'h0C, 16'(1 << (8 + s)));
            rd(8'h0C, d); chk("R7 write one clears flag", 32'(d), 0);
            chk("R13 irq after clear", 32'(host_irq), 0);
            // slow selected, only fast ticks running: no timeout
            wr(8'(2 + 2*s), 16'h0000);
            do_cycle(s, 2'b00, 3*TT, w, b, is, t, dn);
            chk("R8 slow select ignores fast tick", 32'(b), 32'(3*TT));
            chk("R8 no timeout marker", 32'(t), 0);
            tick_slow = 1'b1; tick_fast = 1'b0;
            do_cycle(s, 2'b00, 0, w, b, is, t, dn);
            chk("R8 slow tick timeout length", 32'(b), 32'(TT));
            chk("R13 timeout without enable", 32'(host_irq), 0);
            rd(8'h0C, d); chk("R7 flag without enable", 32'(d), 32'(1 << (8 + s)));
            wr(8'h0C, 16'hFFFF);
            tick_slow = 1'b0; tick_fast = 1'b1;
        end

        // R10 error mirrors
        for (int e = 0; e < 16; e++) begin
            mod_err_n = 4'(e);
            rd(8'h0C, d); chk("R10 error mirror", 32'(d[15:12]), 32'(~e & 15));
            wr(8'h0C, 16'hF000);
            rd(8'h0C, d); chk("R10 error write ignored", 32'(d[15:12]), 32'(~e & 15));
        end
        mod_err_n = 4'hF;

        // R12 level mode
        for (int p = 0; p < 256; p++) begin
            mod_irq_n = 8'(p);
            rd(8'h0C, d); chk("R12 level follows line", 32'(d[7:0]), 32'(~p & 255));
            chk("R13 irq from level", 32'(host_irq), (p != 255) ? 1 : 0);
        end
        mod_irq_n = 8'h00;
        wr(8'h0C, 16'h00FF);
        rd(8'h0C, d); chk("R12 write ignored in level mode", 32'(d[7:0]), 32'hFF);
        mod_irq_n = 8'hFF;
        @(negedge clk);

        // R11 edge mode
        for (int s = 0; s < 4; s++) wr(8'(2 + 2*s), 16'h0018);
        for (int i = 0; i < 8; i++) begin
            mod_irq_n[i] = 1'b0;
            @(negedge clk);
            rd(8'h0C, d); chk("R11 edge latched", 32'(d[7:0]), 32'(1 << i));
            chk("R13 irq from edge latch", 32'(host_irq), 1);
            mod_irq_n[i] = 1'b1;
            @(negedge clk);
            rd(8'h0C, d); chk("R11 latch holds after release", 32'(d[7:0]), 32'(1 << i));
            wr(8'h0C, 16'h0000);
            rd(8'h0C, d); chk("R11 write zero keeps latch", 32'(d[7:0]), 32'(1 << i));
            wr(8'h0C, 16'(1 << i));
            rd(8'h0C, d); chk("R11 write one clears latch", 32'(d[7:0]), 0);
            chk("R13 irq after latch clear", 32'(host_irq), 0);
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule